// File: doc/BRIEF.md
# Prescaled Timer Counter Control

This block is a 16-bit up-counter clocked through a selectable power-of-two divider of the bus clock. Software manages it through a small register port. The control register holds a halt bit, a clear strobe and a 3-bit divider select. A modulo register sets the terminal count. A sticky wrap flag records each pass through that terminal count.

A free-running 6-bit divider produces a one-cycle count enable for the chosen ratio. The clear strobe is not stored: it resets the counter and the divider on the clock edge of the write. It can be combined with the halt bit to park the counter at zero. A wait-mode input exists at the boundary but does not gate counting.

Register map, selected by `reg_addr_i`:
- Address 0 is control: bits [2:0] select the divider, bit 4 is the clear strobe, bit 5 is halt and bit 7 is the wrap flag. All other bits read 0.
- Address 1 is the counter. It is read-only.
- Address 2 is the modulo register.
- Address 3 reads 0.

Top module: `tmr_unit`

## Requirements
- R1: After rst_ni is released, halt reads 1, the divider select reads 000, modulo reads 0xFFFF, the counter reads 0 and the wrap flag is 0. The counter does not move until halt is written to 0.
- R2: While halt (control bit 5) is 1, the counter holds its value. Writing halt to 0 lets counting resume from the held value.
- R3: Writing 1 to control bit 4 clears the counter and the divider on the clock edge of that write. The modulo register and the wrap flag are unchanged.
- R4: Control bit 4 always reads 0.
- R5: A single write with both bit 4 and bit 5 set leaves the counter at 0x0000, and it stays there.
- R6: Divider select k, for k from 0 to 6, advances the counter once every 2^k bus cycles. The advance happens on the edge where the low k bits of the divider are all ones; the divider restarts at 0 after a clear.
- R7: Divider select 111 gives no count enable, and the counter holds its value.
- R8: Changing the divider select without a clear does not reset the divider. The new ratio applies from the next enable.
- R9: When an enable finds the counter equal to the modulo value, the counter goes to 0x0000 and the wrap flag (control bit 7, also ovf_o) is set.
- R10: If the counter is above the modulo value, it counts on through 0xFFFF to 0x0000 without setting the flag.
- R11: The wrap flag clears only on a control write with bit 7 = 0 that follows a control read which returned bit 7 = 1. A new wrap in the same cycle wins over the clear.
- R12: wait_i has no effect on counting.
- R13: Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wait_i | input | 1 | Wait-mode indication (no effect on counting) |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| count_o | output | 16 | Current counter value |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
A divider that is out of phase shows up on count_o at the first enable after a clear or a select change, at most 64 cycles later. A wrong halt or select state is visible on the next cycle, either as a counter that moves when it should be held or one that stalls. A stale modulo value or a missed wrap shows up on ovf_o and on control bit 7 in the cycle after the counter reaches its terminal value. A bad arming state appears as a flag that survives, or is lost on, the first control write after a read. The bench tracks every cycle against a behavioural model, so each of these is reported in the cycle it first occurs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 3;
  localparam int ADDR_W = 2;
  localparam int DIV_W  = (1 << PS_W) - 2;

  localparam int BIT_FLAG = 7;
  localparam int BIT_HALT = 5;
  localparam int BIT_CLR  = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_MOD   = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic            halt;
    logic [PS_W-1:0] ps;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W  = tmr_pkg::PS_W,
  parameter int DIV_W = (1 << PS_W) - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int NTAP = 1 << PS_W;

  logic [DIV_W-1:0] div_q;
  logic [NTAP-1:0]  tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else            div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  // tap k fires when the low k divider bits are all ones; taps past DIV_W are reserved
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_div1
      assign tap[k] = 1'b1;
    end else if (k <= DIV_W) begin : g_divn
      assign tap[k] = &div_q[k-1:0];
    end else begin : g_off
      assign tap[k] = 1'b0;
    end
  end

  assign tick_o = tap[ps_i];

  // R6
  div2_cadence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_i == 1 && tick_o && !clr_i) |=> (ps_i != 1 || !tick_o));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = tmr_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv    = tick_i && !halt_i && !clr_i;
  assign wrap_o = adv && (cnt_q == mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign cnt_o = cnt_q;

  // R3
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R2
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !clr_i) |=> $stable(cnt_q));
  // R9
  step_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = tmr_pkg::CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  mod_o,
  output logic              clr_o,
  output logic              ovf_o,
  output logic [CNT_W-1:0]  rdata_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] mod_q;
  logic             ovf_q, armed_q;
  logic             wr_ctrl, rd_ctrl, flag_clr;

  assign wr_ctrl  = wr_i && (reg_sel_e'(addr_i) == REG_CTRL);
  assign rd_ctrl  = rd_i && (reg_sel_e'(addr_i) == REG_CTRL);
  assign clr_o    = wr_ctrl && wdata_i[BIT_CLR];
  assign flag_clr = wr_ctrl && !wdata_i[BIT_FLAG] && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.halt <= 1'b1;
      ctrl_q.ps   <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.halt <= wdata_i[BIT_HALT];
      ctrl_q.ps   <= wdata_i[PS_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         mod_q <= '1;
    else if (wr_i && reg_sel_e'(addr_i) == REG_MOD)      mod_q <= wdata_i;
  end

  // flag: set wins over clear; clear needs a prior read that saw it set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ovf_q <= wrap_i | (ovf_q & ~flag_clr);
      if (flag_clr)               armed_q <= 1'b0;
      else if (rd_ctrl && ovf_q)  armed_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      REG_CTRL: begin
        rdata_o[BIT_FLAG]   = ovf_q;
        rdata_o[BIT_HALT]   = ctrl_q.halt;
        rdata_o[PS_W-1:0]   = ctrl_q.ps;
      end
      REG_COUNT: rdata_o = cnt_i;
      REG_MOD:   rdata_o = mod_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign mod_o  = mod_q;
  assign ovf_o  = ovf_q;

  // R9
  wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_q);
  // R11
  flag_clear_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> $past(armed_q));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wait_i,
  input  logic [1:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic [15:0] count_o,
  output logic        ovf_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] mod;
  logic             clr, tick, wrap;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (count_o),
    .wrap_i  (wrap),
    .ctrl_o  (ctrl),
    .mod_o   (mod),
    .clr_o   (clr),
    .ovf_o   (ovf_o),
    .rdata_o (reg_rdata_o)
  );

  tmr_prescaler #(.PS_W(PS_W), .DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .ps_i   (ctrl.ps),
    .tick_o (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick),
    .halt_i (ctrl.halt),
    .mod_i  (mod),
    .cnt_o  (count_o),
    .wrap_o (wrap)
  );

  // R7
  reserved_sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.ps == '1 && !clr) |=> $stable(count_o));
  // R12
  wait_no_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && tick && !ctrl.halt && !clr) |=> count_o != $past(count_o));
  // R4
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> !reg_rdata_o[BIT_CLR]);
endmodule

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wait_s = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata, count;
  logic        ovf;

  always #2 clk = ~clk;

  tmr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wait_i(wait_s),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .count_o(count), .ovf_o(ovf)
  );

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_cnt, m_div, m_halt, m_ps, m_mod, m_ovf, m_armed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_halt = 1; m_ps = 0; m_mod = 65535; m_ovf = 0; m_armed = 0;
    end else begin
      int period, tick, clr, adv, set, fclr;
      clr    = (wr && addr == 0 && wdata[4]) ? 1 : 0;
      period = 1 << m_ps;
      tick   = (m_ps != 7 && (m_div % period) == period - 1) ? 1 : 0;
      adv    = tick && !m_halt && !clr;
      set    = adv && (m_cnt == m_mod);
      fclr   = (wr && addr == 0 && !wdata[7] && m_armed) ? 1 : 0;
      if (clr) m_cnt = 0;
      else if (set) m_cnt = 0;
      else if (adv) m_cnt = (m_cnt + 1) % 65536;
      m_div = clr ? 0 : (m_div + 1) % 64;
      if (fclr) m_armed = 0;
      else if (rd && addr == 0 && m_ovf) m_armed = 1;
      m_ovf = set ? 1 : (fclr ? 0 : m_ovf);
      if (wr && addr == 0) begin m_halt = wdata[5]; m_ps = wdata[2:0]; end
      if (wr && addr == 2) m_mod = wdata;
    end
  end

  function automatic int exp_rdata();
    case (addr)
      2'd0: return (m_ovf << 7) | (m_halt << 5) | m_ps;
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (count !== 16'(m_cnt) || ovf !== 1'(m_ovf) || rdata !== 16'(exp_rdata())) begin
        n_fail++;
        $display("FAIL %s: count %h ovf %0b rdata %h, expected count %h ovf %0d rdata %h",
                 cur_req, count, ovf, rdata, 16'(m_cnt), m_ovf, 16'(exp_rdata()));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: cycles %0d, expected below 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] ctl(input bit flag, input bit halt, input bit clr, input int ps);
    return 16'((flag << 7) | (halt << 5) | (clr << 4) | (ps & 7));
  endfunction

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    addr = a; wr = 1'b1; wdata = d;
    @(posedge clk); #1; wr = 1'b0;
  endtask
  task automatic rreg(input logic [1:0] a);
    addr = a; rd = 1'b1;
    @(posedge clk); #1; rd = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset values on all registers
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin rreg(2'(a)); idle(3); end
    // R2 / R12: run, halt, resume with wait toggling
    cur_req = "R12";
    wreg(2'd0, ctl(0, 0, 0, 0));
    for (int i = 0; i < 20; i++) begin wait_s = i[1]; idle(1); end
    wait_s = 1'b0;
    cur_req = "R2";
    wreg(2'd0, ctl(0, 1, 0, 0)); idle(10);
    wreg(2'd0, ctl(0, 0, 0, 0)); idle(10);
    // R13: counter register is read-only
    cur_req = "R13";
    wreg(2'd1, 16'h1234); addr = 2'd1; idle(5);
    // R3 / R4: clear strobe while running
    cur_req = "R3";
    wreg(2'd2, 16'h8000);
    wreg(2'd0, ctl(0, 0, 1, 0)); addr = 2'd2; idle(5);
    cur_req = "R4";
    addr = 2'd0; idle(3);
    // R5: halt and clear together
    cur_req = "R5";
    wreg(2'd0, ctl(0, 1, 1, 0)); addr = 2'd1; idle(12);
    // R6: each divider ratio from a clear
    cur_req = "R6";
    for (int k = 1; k <= 6; k++) begin
      wreg(2'd0, ctl(0, 0, 1, k)); idle(3 << k);
    end
    // R8: ratio change without clear
    cur_req = "R8";
    wreg(2'd0, ctl(0, 0, 0, 2)); idle(7);
    wreg(2'd0, ctl(0, 0, 0, 4)); idle(40);
    wreg(2'd0, ctl(0, 0, 0, 1)); idle(9);
    // R7: reserved select holds the counter
    cur_req = "R7";
    wreg(2'd0, ctl(0, 0, 0, 7)); idle(80);
    // R9: terminal count wrap and flag
    cur_req = "R9";
    wreg(2'd2, 16'd10);
    wreg(2'd0, ctl(0, 0, 1, 0)); idle(15);
    // R11: clear sequence
    cur_req = "R11";
    wreg(2'd0, ctl(0, 1, 0, 0)); idle(2);
    rreg(2'd0); idle(2);
    wreg(2'd0, ctl(0, 1, 0, 0)); idle(2);
    wreg(2'd0, ctl(0, 0, 1, 0)); idle(14);
    rreg(2'd0);
    wreg(2'd0, ctl(1, 0, 0, 0)); idle(2);
    wreg(2'd0, ctl(0, 0, 0, 0)); idle(3);
    // R11: wrap in the same cycle as an armed clear; set wins
    wreg(2'd2, 16'd4);
    wreg(2'd0, ctl(0, 0, 1, 0)); idle(5);
    rreg(2'd0);
    idle(1);
    wreg(2'd0, ctl(0, 0, 0, 0)); idle(4);
    // R10: counter above modulo wraps through 0xFFFF without flag
    cur_req = "R10";
    rreg(2'd0);
    wreg(2'd0, ctl(0, 1, 0, 0));
    wreg(2'd2, 16'hFFFF);
    wreg(2'd0, ctl(0, 0, 1, 0)); idle(20);
    wreg(2'd2, 16'd5); idle(65560);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule